// File: doc/BRIEF.md
# Hysteretic Converter Toggle Controller

This block is the central lower-bound controller for a switched-capacitor converter that is built from many identical unit cells. On each tick of the fast sampling clock it reads the comparator result that reports whether the converter output has fallen below its reference. It drives one toggle line, and every unit cell changes between its two phases when that line changes, so all cells switch in the same cycle. When the output falls below the reference, the controller flips the toggle. When the output stays low after that, a watchdog counter forces further flips at a bounded rate.

The controller also holds the active conversion mode. From that mode it drives a one-hot reference-select output and chooses which comparator result it listens to. A hold input parks the controller in its reset state for a mode change. While held, the toggle sits in phase 1 and the comparators are ignored. The new mode is taken in only during this hold. Two free-running event counters let a test count the flips and see which of them were forced.

Top module: `hys_toggle_ctrl`

## Requirements
- R1: After reset the toggle is 0 (phase 1), both event counters are 0, the active mode is 0 (ref_sel_o = 4'b0001), and the dual-comparator path is enabled.
- R2: A sample in which the selected comparator result is 1, after a sample in which it was 0, flips toggle_o at that same clock edge.
- R3: While the selected result stays 1, the controller forces a further flip on every Lth consecutive high sample after the last flip. L is the effective limit, and forced_cnt_o increments with each forced flip.
- R4: A sample in which the selected result is 0 clears the watchdog count. The next 1 is then treated as a new rising edge.
- R5: The effective limit L is ovf_limit_i, raised to MIN_GAP (default 4) when it is smaller. Two flips are therefore never closer than MIN_GAP cycles while the result stays high.
- R6: While mode_hold_i is 1, toggle_o is driven to 0, no flip occurs, the counters do not change, and the comparator inputs are ignored.
- R7: Comparator history is cleared during a hold. A result of 1 on the first sample after the hold is released counts as a rising edge.
- R8: The mode is loaded from mode_sel_i only while mode_hold_i is 1, and is ignored at other times. ref_sel_o is one-hot with bit n set for mode n (0: 1.0 V, 1: 0.9 V, 2: 0.67 V, 3: 0.5 V from 1 V at 2:1).
- R9: In mode 3 only cmp_single_i is used, and cmp_pair_en_o is 0. In modes 0 to 2 the result is cmp_rise_i OR cmp_fall_i, cmp_single_i is ignored, and cmp_pair_en_o is 1.
- R10: toggle_cnt_o increments on every flip, whether from an edge or forced. forced_cnt_o increments only on forced flips. Both counters wrap modulo 2^CNT_W.
- R11: When a hold arrives in the cycle in which a forced flip would occur, the hold wins: no flip and no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Comparator sampling clock, the only clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel_i | input | 2 | Requested conversion mode, loaded during a hold |
| mode_hold_i | input | 1 | Holds the controller in its reset state for a mode change |
| cmp_single_i | input | 1 | Below-reference result of the single comparator (mode 3) |
| cmp_rise_i | input | 1 | Below-reference result of the comparator sampled on the rising edge |
| cmp_fall_i | input | 1 | Below-reference result of the comparator sampled on the falling edge, already retimed |
| ovf_limit_i | input | LIM_W | Programmed watchdog limit |
| toggle_o | output | 1 | Phase toggle to all unit cells |
| ref_sel_o | output | 4 | One-hot reference voltage select |
| cmp_pair_en_o | output | 1 | Dual-comparator path enabled |
| toggle_cnt_o | output | CNT_W | Count of all flips |
| forced_cnt_o | output | CNT_W | Count of forced flips |

## Verification
Two functions can fall in the same cycle: a forced flip from the watchdog and a hold request for a mode change. The bench lets the comparator stay high until the watchdog count sits one sample short of its limit. It then raises the hold in that very sample, with the comparator still high. The result is judged at the ports: toggle_o must read 0 rather than flip to 1, both counters must be unchanged, and the new mode must appear on ref_sel_o.

// File: rtl/hys_pkg.sv
package hys_pkg;
  localparam int NUM_MODES = 4;

  typedef enum logic [1:0] {
    MODE_1V0  = 2'd0,
    MODE_0V9  = 2'd1,
    MODE_0V67 = 2'd2,
    MODE_0V5  = 2'd3
  } conv_mode_e;

  // the low-voltage 2:1 mode from the 1 V rail runs on one comparator
  function automatic logic mode_is_single(conv_mode_e m);
    return (m == MODE_0V5);
  endfunction
endpackage

// File: rtl/hys_cmp_select.sv
module hys_cmp_select
  import hys_pkg::*;
(
  input  conv_mode_e             mode_i,
  input  logic                   single_i,
  input  logic                   rise_i,
  input  logic                   fall_i,
  output logic                   below_o,
  output logic                   pair_en_o,
  output logic [NUM_MODES-1:0]   ref_sel_o
);
  always_comb begin
    pair_en_o = !mode_is_single(mode_i);
    below_o   = pair_en_o ? (rise_i | fall_i) : single_i;
  end

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_ref
    assign ref_sel_o[g] = (mode_i == conv_mode_e'(g));
  end
endmodule

// File: rtl/hys_trigger.sv
module hys_trigger #(
  parameter int LIM_W   = 8,
  parameter int MIN_GAP = 4
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             below_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             edge_o,
  output logic             force_o
);
  localparam logic [LIM_W-1:0] GAP_V = LIM_W'(MIN_GAP);

  logic             seen_q, seen_d;
  logic [LIM_W-1:0] cnt_q, cnt_d;
  logic [LIM_W-1:0] lim_eff, lim_m1;

  always_comb begin
    lim_eff = (limit_i < GAP_V) ? GAP_V : limit_i;
    lim_m1  = lim_eff - 1'b1;
  end

  always_comb begin
    seen_d  = seen_q;
    cnt_d   = cnt_q;
    edge_o  = 1'b0;
    force_o = 1'b0;
    if (clr_i || !below_i) begin
      seen_d = 1'b0;
      cnt_d  = '0;
    end else if (!seen_q) begin
      seen_d = 1'b1;
      cnt_d  = '0;
      edge_o = 1'b1;
    end else if (cnt_q == lim_m1) begin
      cnt_d   = '0;
      force_o = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      seen_q <= seen_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/hys_phase_reg.sv
module hys_phase_reg
  import hys_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  conv_mode_e       mode_req_i,
  input  logic             edge_i,
  input  logic             force_i,
  output logic             toggle_o,
  output conv_mode_e       mode_o,
  output logic [CNT_W-1:0] tcnt_o,
  output logic [CNT_W-1:0] fcnt_o
);
  logic             tog_d, tcnt_en, fcnt_en, mode_en;
  logic [CNT_W-1:0] tcnt_d, fcnt_d;

  always_comb begin
    mode_en = hold_i;
    tcnt_en = !hold_i && (edge_i || force_i);
    fcnt_en = !hold_i && force_i;
    tog_d   = hold_i ? 1'b0 : (tcnt_en ? !toggle_o : toggle_o);
    tcnt_d  = tcnt_o + 1'b1;
    fcnt_d  = fcnt_o + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      toggle_o <= 1'b0;
      mode_o   <= MODE_1V0;
      tcnt_o   <= '0;
      fcnt_o   <= '0;
    end else begin
      toggle_o <= tog_d;
      if (mode_en) mode_o <= mode_req_i;
      if (tcnt_en) tcnt_o <= tcnt_d;
      if (fcnt_en) fcnt_o <= fcnt_d;
    end
  end
endmodule

// File: rtl/hys_toggle_ctrl.sv
module hys_toggle_ctrl
  import hys_pkg::*;
#(
  parameter int LIM_W   = 8,
  parameter int CNT_W   = 16,
  parameter int MIN_GAP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel_i,
  input  logic             mode_hold_i,
  input  logic             cmp_single_i,
  input  logic             cmp_rise_i,
  input  logic             cmp_fall_i,
  input  logic [LIM_W-1:0] ovf_limit_i,
  output logic             toggle_o,
  output logic [3:0]       ref_sel_o,
  output logic             cmp_pair_en_o,
  output logic [CNT_W-1:0] toggle_cnt_o,
  output logic [CNT_W-1:0] forced_cnt_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  conv_mode_e mode_q;
  logic       below, evt_edge, evt_force;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  hys_cmp_select u_sel (
    .mode_i    (mode_q),
    .single_i  (cmp_single_i),
    .rise_i    (cmp_rise_i),
    .fall_i    (cmp_fall_i),
    .below_o   (below),
    .pair_en_o (cmp_pair_en_o),
    .ref_sel_o (ref_sel_o)
  );

  hys_trigger #(.LIM_W(LIM_W), .MIN_GAP(MIN_GAP)) u_trig (
    .clk     (clk),
    .rst_ni  (rst_int_n),
    .clr_i   (mode_hold_i),
    .below_i (below),
    .limit_i (ovf_limit_i),
    .edge_o  (evt_edge),
    .force_o (evt_force)
  );

  hys_phase_reg #(.CNT_W(CNT_W)) u_phase (
    .clk        (clk),
    .rst_ni     (rst_int_n),
    .hold_i     (mode_hold_i),
    .mode_req_i (conv_mode_e'(mode_sel_i)),
    .edge_i     (evt_edge),
    .force_i    (evt_force),
    .toggle_o   (toggle_o),
    .mode_o     (mode_q),
    .tcnt_o     (toggle_cnt_o),
    .fcnt_o     (forced_cnt_o)
  );
endmodule

// File: rtl/hys_toggle_ctrl_chk.sv
module hys_toggle_ctrl_chk #(
  parameter int CNT_W   = 16,
  parameter int MIN_GAP = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_hold_i,
  input logic             toggle_o,
  input logic [3:0]       ref_sel_o,
  input logic [CNT_W-1:0] toggle_cnt_o,
  input logic [CNT_W-1:0] forced_cnt_o
);
  logic [CNT_W-1:0] prev_tcnt;
  logic [15:0]      since_flip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_tcnt  <= '0;
      since_flip <= '0;
    end else begin
      prev_tcnt <= toggle_cnt_o;
      if (toggle_cnt_o != prev_tcnt) since_flip <= 16'd1;
      else if (since_flip != 16'hFFFF) since_flip <= since_flip + 16'd1;
    end
  end

  // R6
  hold_phase1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_hold_i |=> !toggle_o);

  // R6
  hold_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_hold_i |=> $stable(toggle_cnt_o));

  // R2
  flip_counted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!mode_hold_i) && (toggle_o != $past(toggle_o))) |->
      (toggle_cnt_o != $past(toggle_cnt_o)));

  // R10
  forced_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (forced_cnt_o != $past(forced_cnt_o)) |-> (toggle_cnt_o != $past(toggle_cnt_o)));

  // R8
  ref_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ref_sel_o) == 1);

  // R8
  mode_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_hold_i |=> $stable(ref_sel_o));

  // R5
  min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (forced_cnt_o != $past(forced_cnt_o)) |-> (since_flip >= 16'(MIN_GAP)));
endmodule

bind hys_toggle_ctrl hys_toggle_ctrl_chk #(.CNT_W(CNT_W), .MIN_GAP(MIN_GAP)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_hold_i  (mode_hold_i),
  .toggle_o     (toggle_o),
  .ref_sel_o    (ref_sel_o),
  .toggle_cnt_o (toggle_cnt_o),
  .forced_cnt_o (forced_cnt_o)
);

// File: tb/tb_hys_toggle_ctrl.sv
module tb_hys_toggle_ctrl;
  localparam int CW    = 8;
  localparam int LW    = 8;
  localparam int CLK_P = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    mode_sel;
  logic          hold, c_single, c_rise, c_fall;
  logic [LW-1:0] limit;
  logic          toggle, pair_en;
  logic [3:0]    ref_sel;
  logic [CW-1:0] tcnt, fcnt;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  hys_toggle_ctrl #(.LIM_W(LW), .CNT_W(CW), .MIN_GAP(4)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_sel_i    (mode_sel),
    .mode_hold_i   (hold),
    .cmp_single_i  (c_single),
    .cmp_rise_i    (c_rise),
    .cmp_fall_i    (c_fall),
    .ovf_limit_i   (limit),
    .toggle_o      (toggle),
    .ref_sel_o     (ref_sel),
    .cmp_pair_en_o (pair_en),
    .toggle_cnt_o  (tcnt),
    .forced_cnt_o  (fcnt)
  );

  // {hold, mode[1:0], single, rise, fall, exp_toggle, exp_ref[3:0], exp_tcnt[7:0], exp_fcnt[7:0]}
  localparam logic [26:0] VEC [0:20] = '{
    {1'b0, 2'd0, 3'b000, 1'b0, 4'b0001, 8'd0, 8'd0},
    {1'b0, 2'd0, 3'b010, 1'b1, 4'b0001, 8'd1, 8'd0},
    {1'b0, 2'd0, 3'b010, 1'b1, 4'b0001, 8'd1, 8'd0},
    {1'b0, 2'd0, 3'b001, 1'b1, 4'b0001, 8'd1, 8'd0},
    {1'b0, 2'd0, 3'b011, 1'b1, 4'b0001, 8'd1, 8'd0},
    {1'b0, 2'd0, 3'b010, 1'b1, 4'b0001, 8'd1, 8'd0},
    {1'b0, 2'd0, 3'b010, 1'b0, 4'b0001, 8'd2, 8'd1},
    {1'b0, 2'd0, 3'b000, 1'b0, 4'b0001, 8'd2, 8'd1},
    {1'b0, 2'd0, 3'b100, 1'b0, 4'b0001, 8'd2, 8'd1},
    {1'b0, 2'd0, 3'b001, 1'b1, 4'b0001, 8'd3, 8'd1},
    {1'b0, 2'd0, 3'b000, 1'b1, 4'b0001, 8'd3, 8'd1},
    {1'b0, 2'd3, 3'b010, 1'b0, 4'b0001, 8'd4, 8'd1},
    {1'b1, 2'd3, 3'b010, 1'b0, 4'b1000, 8'd4, 8'd1},
    {1'b1, 2'd3, 3'b000, 1'b0, 4'b1000, 8'd4, 8'd1},
    {1'b0, 2'd3, 3'b011, 1'b0, 4'b1000, 8'd4, 8'd1},
    {1'b0, 2'd3, 3'b100, 1'b1, 4'b1000, 8'd5, 8'd1},
    {1'b0, 2'd3, 3'b100, 1'b1, 4'b1000, 8'd5, 8'd1},
    {1'b0, 2'd3, 3'b111, 1'b1, 4'b1000, 8'd5, 8'd1},
    {1'b0, 2'd3, 3'b100, 1'b1, 4'b1000, 8'd5, 8'd1},
    {1'b0, 2'd3, 3'b100, 1'b1, 4'b1000, 8'd5, 8'd1},
    {1'b0, 2'd3, 3'b100, 1'b0, 4'b1000, 8'd6, 8'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic h, input logic [1:0] m, input logic s,
                      input logic r, input logic f);
    @(negedge clk);
    hold = h; mode_sel = m; c_single = s; c_rise = r; c_fall = f;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; hold = 1'b0; mode_sel = 2'd0;
    c_single = 1'b0; c_rise = 1'b0; c_fall = 1'b0; limit = 8'd5;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 toggle", 32'(toggle), 32'd0);
    chk("R1 tcnt", 32'(tcnt), 32'd0);
    chk("R1 fcnt", 32'(fcnt), 32'd0);
    chk("R1 ref_sel", 32'(ref_sel), 32'b0001);
    chk("R1 pair_en", 32'(pair_en), 32'd1);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // table: R2 edges, R3 forced flips, R4 clear, R9 path, R8 mode load, R6 hold
    for (int i = 0; i < 21; i++) begin
      step(VEC[i][26], VEC[i][25:24], VEC[i][23], VEC[i][22], VEC[i][21]);
      chk($sformatf("R2 R3 toggle row %0d", i), 32'(toggle), 32'(VEC[i][20]));
      chk($sformatf("R8 ref row %0d", i), 32'(ref_sel), 32'(VEC[i][19:16]));
      chk($sformatf("R10 tcnt row %0d", i), 32'(tcnt), 32'(VEC[i][15:8]));
      chk($sformatf("R10 fcnt row %0d", i), 32'(fcnt), 32'(VEC[i][7:0]));
    end
    chk("R9 pair_en in mode 3", 32'(pair_en), 32'd0);

    // R7: comparator high across a hold counts as a fresh edge on release
    limit = 8'd1;
    step(1'b1, 2'd1, 1'b1, 1'b1, 1'b0);
    chk("R6 hold toggle", 32'(toggle), 32'd0);
    chk("R8 ref mode 1", 32'(ref_sel), 32'b0010);
    chk("R9 pair_en in mode 1", 32'(pair_en), 32'd1);
    step(1'b0, 2'd1, 1'b0, 1'b1, 1'b0);
    chk("R7 restart edge toggle", 32'(toggle), 32'd1);
    chk("R7 restart edge tcnt", 32'(tcnt), 32'd7);
    // R5: limit 1 is raised to 4
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 2'd1, 1'b0, 1'b1, 1'b0);
      chk("R5 no early force", 32'(fcnt), 32'd2);
    end
    step(1'b0, 2'd1, 1'b0, 1'b1, 1'b0);
    chk("R5 forced at floor", 32'(fcnt), 32'd3);
    chk("R5 toggle", 32'(toggle), 32'd0);
    chk("R5 tcnt", 32'(tcnt), 32'd8);

    // R11: hold in the cycle a forced flip is due
    for (int k = 0; k < 3; k++) step(1'b0, 2'd1, 1'b0, 1'b1, 1'b0);
    step(1'b1, 2'd2, 1'b0, 1'b1, 1'b0);
    chk("R11 hold beats force toggle", 32'(toggle), 32'd0);
    chk("R11 hold beats force tcnt", 32'(tcnt), 32'd8);
    chk("R11 hold beats force fcnt", 32'(fcnt), 32'd3);
    chk("R11 new mode", 32'(ref_sel), 32'b0100);
    step(1'b0, 2'd2, 1'b0, 1'b0, 1'b0);

    // R4: a low sample clears the count
    limit = 8'd5;
    step(1'b0, 2'd2, 1'b0, 1'b1, 1'b0);
    for (int k = 0; k < 3; k++) step(1'b0, 2'd2, 1'b0, 1'b1, 1'b0);
    step(1'b0, 2'd2, 1'b0, 1'b0, 1'b0);
    step(1'b0, 2'd2, 1'b0, 1'b0, 1'b1);
    chk("R4 edge after gap toggle", 32'(toggle), 32'd0);
    chk("R4 edge after gap tcnt", 32'(tcnt), 32'd10);
    for (int k = 0; k < 4; k++) step(1'b0, 2'd2, 1'b0, 1'b0, 1'b1);
    chk("R4 count restarted", 32'(fcnt), 32'd3);
    step(1'b0, 2'd2, 1'b0, 1'b0, 1'b1);
    chk("R3 forced after restart", 32'(fcnt), 32'd4);
    chk("R3 forced toggle", 32'(toggle), 32'd1);
    step(1'b0, 2'd2, 1'b0, 1'b0, 1'b0);

    // R10: wrap of the flip counter
    for (int k = 0; k < 245; k++) begin
      step(1'b0, 2'd2, 1'b0, 1'b1, 1'b0);
      step(1'b0, 2'd2, 1'b0, 1'b0, 1'b0);
    end
    chk("R10 tcnt wrap", 32'(tcnt), 32'd0);
    chk("R10 fcnt unchanged", 32'(fcnt), 32'd4);
    chk("R10 toggle parity", 32'(toggle), 32'd0);

    // R1: asynchronous reset mid-run
    step(1'b0, 2'd2, 1'b0, 1'b1, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R1 async toggle", 32'(toggle), 32'd0);
    chk("R1 async tcnt", 32'(tcnt), 32'd0);
    chk("R1 async ref", 32'(ref_sel), 32'b0001);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule